// File: doc/BRIEF.md
# Square-Pixel Line Formatter with Embedded Sync

This block produces the 8-bit multiplexed YCbCr byte stream for square-pixel standard-definition video, one byte per clock. A mode input selects 525-line/60 Hz or 625-line/50 Hz timing. Internal counters follow the clock position within the line and the line within the frame. In embedded-sync operation each line carries an end-of-active-video reference code, a horizontal blanking fill, a start-of-active-video reference code and then the active region. In the active region the block asks an upstream pixel source for samples in chroma-blue, luma, chroma-red, luma order.

For external-sync operation the reference codes are left out. Instead, an active-low horizontal sync pulse and a data-valid flag mark where the pixels sit, and the pixel window starts at a fixed offset after the sync edge. Frame line counts, field boundaries and vertical-blanking spans are parameters. The horizontal budgets default to the square-pixel values.

Top module: `lf_sqpix_formatter`

## Requirements
- R1: In embedded mode, line position h=0..3 carries the end code, then blanking lasts 272 clocks (525-line mode) or 344 clocks (625-line mode), then a 4-clock start code, then 1280 or 1536 active clocks.
- R2: A line is 1560 clocks (525-line mode) or 1888 clocks (625-line mode). A frame is LINES_A or LINES_B lines (default 525 and 625), after which the line count returns to 0.
- R3: Each reference code is the bytes 0xFF, 0x00, 0x00, XY, where XY = {1, F, V, H, V^H, F^H, F^V, F^V^H} from bit 7 down to bit 0. H=1 in the end code and H=0 in the start code.
- R4: F is 1 for lines at or after the field-two start line (FLD2_A/FLD2_B). V is 1 for the first VBLK_A/VBLK_B lines of each field.
- R5: Every blanking byte is 0x80 at an even line position and 0x10 at an odd one, so each blanking run starts with 0x80.
- R6: pix_req is high in the cycle before a requested sample appears on vid_out. The vid_out byte then equals the pix_in value present at the clock edge that ends the pix_req cycle. pix_sel gives the component as 0=Cb, 1=Y, 2=Cr, 3=Y, starting at 0 at the start of every pixel window. pix_in has no effect in any other cycle.
- R7: On lines with V=1, the active region carries blanking bytes and pix_req stays low.
- R8: In external-sync mode, no reference codes are sent. The pixel window starts at h=236 (525-line) or h=308 (625-line) and lasts 1280 or 1536 clocks. All other bytes are blanking.
- R9: hsync_n is low exactly while vid_out shows line positions 0..3. data_valid is high exactly when vid_out carries a pixel sample.
- R10: mode_625 is taken only at reset and on the last clock of a frame. ext_sync is taken only at reset and on the last clock of a line.
- R11: While in reset and on the first clock after it, vid_out=0x10, hsync_n=1, data_valid=0 and pix_req=0. Line position 0 of line 0 appears on vid_out two clocks after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_625 | input | 1 | 1 selects 625-line timing, 0 selects 525-line timing |
| ext_sync | input | 1 | 1 selects external-sync layout without reference codes |
| pix_in | input | 8 | Sample from the upstream source |
| pix_req | output | 1 | Sample request, one clock ahead of its output slot |
| pix_sel | output | 2 | Component of the requested sample |
| vid_out | output | 8 | Multiplexed video byte stream |
| hsync_n | output | 1 | Active-low horizontal sync |
| data_valid | output | 1 | vid_out carries a pixel sample |

## Verification
The riskiest coincidence is a mode change on the last clock of a frame. In that same cycle the line counter wraps, the new line's end code is formed from the new mode's field flags, and the line length switches. The bench drives mode_625 high for that single clock only. It then checks that the following frame follows 625-line positions from its first byte and reverts at the next frame end. External-sync changes are thrown at random positions within lines, so the line-wrap latch also coincides with the end-code slot. The bench judges every byte, sync and request against a position model that it advances on its own.

// File: rtl/lf_pkg.sv
package lf_pkg;

  typedef enum logic [1:0] {
    SEG_BLANK = 2'd0,
    SEG_CODE  = 2'd1,
    SEG_PIX   = 2'd2
  } seg_e;

  // One decoded line slot, carried between the decode and output stages.
  typedef struct packed {
    seg_e       seg;
    logic [1:0] idx;   // code byte index or pixel component
    logic       hbit;  // end code (1) or start code (0)
    logic       fld;
    logic       vbl;
    logic       odd;   // line position parity, picks the blanking level
    logic       sync;  // slot lies inside the sync pulse
  } slot_t;

  localparam logic [7:0] LVL_EVEN = 8'h80;
  localparam logic [7:0] LVL_ODD  = 8'h10;
  localparam logic [7:0] PRE_HI   = 8'hFF;
  localparam logic [7:0] PRE_LO   = 8'h00;

  localparam slot_t SLOT_IDLE = '{seg: SEG_BLANK, idx: 2'd0, hbit: 1'b0,
                                  fld: 1'b0, vbl: 1'b0, odd: 1'b1, sync: 1'b0};

  function automatic logic [7:0] ref_word(input logic fld, input logic vbl,
                                          input logic hbit);
    return {1'b1, fld, vbl, hbit, vbl ^ hbit, fld ^ hbit, fld ^ vbl,
            fld ^ vbl ^ hbit};
  endfunction

  function automatic logic [7:0] code_byte(input logic [1:0] idx, input logic fld,
                                           input logic vbl, input logic hbit);
    logic [7:0] b;
    case (idx)
      2'd0:    b = PRE_HI;
      2'd3:    b = ref_word(fld, vbl, hbit);
      default: b = PRE_LO;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/lf_timebase.sv
module lf_timebase #(
  parameter int HTOT_A  = 1560,
  parameter int HTOT_B  = 1888,
  parameter int LINES_A = 525,
  parameter int LINES_B = 625,
  parameter int HW      = 11,
  parameter int VW      = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mode_in,
  input  logic          ext_in,
  output logic [HW-1:0] hcnt,
  output logic [VW-1:0] vcnt,
  output logic          mode,
  output logic          ext
);

  logic [HW-1:0] h_last;
  logic [VW-1:0] v_last;
  logic          line_end;
  logic          frame_end;

  always_comb begin
    h_last = mode ? HW'(HTOT_B - 1) : HW'(HTOT_A - 1);
    v_last = mode ? VW'(LINES_B - 1) : VW'(LINES_A - 1);
  end

  assign line_end  = (hcnt == h_last);
  assign frame_end = line_end && (vcnt == v_last);

  always_ff @(posedge clk) begin
    if (rst) begin
      hcnt <= '0;
      vcnt <= '0;
      mode <= mode_in;
      ext  <= ext_in;
    end else if (line_end) begin
      hcnt <= '0;
      ext  <= ext_in;
      if (frame_end) begin
        vcnt <= '0;
        mode <= mode_in;
      end else begin
        vcnt <= vcnt + 1'b1;
      end
    end else begin
      hcnt <= hcnt + 1'b1;
    end
  end

  a_r2_line_wrap: assert property (@(posedge clk) disable iff (rst)
    line_end |=> (hcnt == '0));
  a_r2_h_range: assert property (@(posedge clk) disable iff (rst)
    hcnt <= h_last);
  a_r2_v_range: assert property (@(posedge clk) disable iff (rst)
    vcnt <= v_last);
  a_r10_mode_hold: assert property (@(posedge clk) disable iff (rst)
    !frame_end |=> $stable(mode));
  a_r10_ext_hold: assert property (@(posedge clk) disable iff (rst)
    !line_end |=> $stable(ext));

endmodule

// File: rtl/lf_slot_decode.sv
module lf_slot_decode
  import lf_pkg::*;
#(
  parameter int CODE_LEN = 4,
  parameter int SYNC_LEN = 4,
  parameter int BLANK_A  = 272,
  parameter int ACT_A    = 1280,
  parameter int BLANK_B  = 344,
  parameter int ACT_B    = 1536,
  parameter int OFS_A    = 236,
  parameter int OFS_B    = 308,
  parameter int FLD2_A   = 263,
  parameter int FLD2_B   = 313,
  parameter int VBLK_A   = 20,
  parameter int VBLK_B   = 23,
  parameter int HW       = 11,
  parameter int VW       = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [HW-1:0] hcnt,
  input  logic [VW-1:0] vcnt,
  input  logic          mode,
  input  logic          ext,
  output slot_t         slot,
  output logic          pix_req,
  output logic [1:0]    pix_sel
);

  int    h, v, blank_len, act_len, ofs, fld2, vblk, sav_at, act_at;
  slot_t nxt;

  always_comb begin
    h         = int'(hcnt);
    v         = int'(vcnt);
    blank_len = mode ? BLANK_B : BLANK_A;
    act_len   = mode ? ACT_B : ACT_A;
    ofs       = mode ? OFS_B : OFS_A;
    fld2      = mode ? FLD2_B : FLD2_A;
    vblk      = mode ? VBLK_B : VBLK_A;
    sav_at    = CODE_LEN + blank_len;
    act_at    = ext ? ofs : sav_at + CODE_LEN;

    nxt.fld  = (v >= fld2);
    nxt.vbl  = (v < vblk) || ((v >= fld2) && (v < fld2 + vblk));
    nxt.odd  = hcnt[0];
    nxt.sync = (h < SYNC_LEN);
    nxt.hbit = 1'b0;
    nxt.idx  = 2'd0;
    nxt.seg  = SEG_BLANK;

    if (!ext && (h < CODE_LEN)) begin
      nxt.seg  = SEG_CODE;
      nxt.idx  = 2'(h);
      nxt.hbit = 1'b1;
    end else if (!ext && (h >= sav_at) && (h < act_at)) begin
      nxt.seg = SEG_CODE;
      nxt.idx = 2'(h - sav_at);
    end else if ((h >= act_at) && (h < act_at + act_len) && !nxt.vbl) begin
      nxt.seg = SEG_PIX;
      nxt.idx = 2'(h - act_at);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slot    <= SLOT_IDLE;
      pix_req <= 1'b0;
      pix_sel <= 2'd0;
    end else begin
      slot    <= nxt;
      pix_req <= (nxt.seg == SEG_PIX);
      pix_sel <= nxt.idx;
    end
  end

  a_r7_no_req_vblank: assert property (@(posedge clk) disable iff (rst)
    pix_req |-> !slot.vbl);
  a_r6_sel_step: assert property (@(posedge clk) disable iff (rst)
    (pix_req && $past(pix_req)) |-> (pix_sel == $past(pix_sel) + 2'd1));
  a_r6_first_cb: assert property (@(posedge clk) disable iff (rst)
    $rose(pix_req) |-> (pix_sel == 2'd0));

endmodule

// File: rtl/lf_byte_mux.sv
module lf_byte_mux
  import lf_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  slot_t      slot,
  input  logic [7:0] pix_in,
  output logic [7:0] vid_out,
  output logic       hsync_n,
  output logic       data_valid
);

  logic out_blank;
  logic out_xy;

  always_ff @(posedge clk) begin
    if (rst) begin
      vid_out    <= LVL_ODD;
      hsync_n    <= 1'b1;
      data_valid <= 1'b0;
      out_blank  <= 1'b0;
      out_xy     <= 1'b0;
    end else begin
      hsync_n    <= !slot.sync;
      data_valid <= (slot.seg == SEG_PIX);
      out_blank  <= (slot.seg == SEG_BLANK);
      out_xy     <= (slot.seg == SEG_CODE) && (slot.idx == 2'd3);
      case (slot.seg)
        SEG_PIX:  vid_out <= pix_in;
        SEG_CODE: vid_out <= code_byte(slot.idx, slot.fld, slot.vbl, slot.hbit);
        default:  vid_out <= slot.odd ? LVL_ODD : LVL_EVEN;
      endcase
    end
  end

  a_r5_blank_alternate: assert property (@(posedge clk) disable iff (rst)
    (out_blank && $past(out_blank)) |-> (vid_out != $past(vid_out)));
  a_r3_xy_protect: assert property (@(posedge clk) disable iff (rst)
    out_xy |-> (vid_out[7] && (vid_out[3] == (vid_out[5] ^ vid_out[4]))
                && (vid_out[2] == (vid_out[6] ^ vid_out[4]))
                && (vid_out[1] == (vid_out[6] ^ vid_out[5]))
                && (vid_out[0] == (vid_out[6] ^ vid_out[5] ^ vid_out[4]))));
  a_r3_preamble: assert property (@(posedge clk) disable iff (rst)
    out_xy |-> ($past(vid_out, 3) == PRE_HI));
  a_r9_valid_off_sync: assert property (@(posedge clk) disable iff (rst)
    data_valid |-> hsync_n);

endmodule

// File: rtl/lf_sqpix_formatter.sv
module lf_sqpix_formatter #(
  parameter int BLANK_A = 272,
  parameter int ACT_A   = 1280,
  parameter int BLANK_B = 344,
  parameter int ACT_B   = 1536,
  parameter int OFS_A   = 236,
  parameter int OFS_B   = 308,
  parameter int LINES_A = 525,
  parameter int LINES_B = 625,
  parameter int FLD2_A  = 263,
  parameter int FLD2_B  = 313,
  parameter int VBLK_A  = 20,
  parameter int VBLK_B  = 23
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       mode_625,
  input  logic       ext_sync,
  input  logic [7:0] pix_in,
  output logic       pix_req,
  output logic [1:0] pix_sel,
  output logic [7:0] vid_out,
  output logic       hsync_n,
  output logic       data_valid
);
  import lf_pkg::*;

  localparam int CODE_LEN  = 4;
  localparam int SYNC_LEN  = 4;
  localparam int HTOT_A    = 2 * CODE_LEN + BLANK_A + ACT_A;
  localparam int HTOT_B    = 2 * CODE_LEN + BLANK_B + ACT_B;
  localparam int HTOT_MAX  = (HTOT_A > HTOT_B) ? HTOT_A : HTOT_B;
  localparam int LINES_MAX = (LINES_A > LINES_B) ? LINES_A : LINES_B;
  localparam int HW        = (HTOT_MAX > 2) ? $clog2(HTOT_MAX) : 1;
  localparam int VW        = (LINES_MAX > 2) ? $clog2(LINES_MAX) : 1;

  logic [HW-1:0] hcnt;
  logic [VW-1:0] vcnt;
  logic          mode;
  logic          ext;
  slot_t         slot;

  lf_timebase #(
    .HTOT_A(HTOT_A), .HTOT_B(HTOT_B), .LINES_A(LINES_A), .LINES_B(LINES_B),
    .HW(HW), .VW(VW)
  ) u_time (
    .clk(clk), .rst(rst), .mode_in(mode_625), .ext_in(ext_sync),
    .hcnt(hcnt), .vcnt(vcnt), .mode(mode), .ext(ext)
  );

  lf_slot_decode #(
    .CODE_LEN(CODE_LEN), .SYNC_LEN(SYNC_LEN),
    .BLANK_A(BLANK_A), .ACT_A(ACT_A), .BLANK_B(BLANK_B), .ACT_B(ACT_B),
    .OFS_A(OFS_A), .OFS_B(OFS_B), .FLD2_A(FLD2_A), .FLD2_B(FLD2_B),
    .VBLK_A(VBLK_A), .VBLK_B(VBLK_B), .HW(HW), .VW(VW)
  ) u_dec (
    .clk(clk), .rst(rst), .hcnt(hcnt), .vcnt(vcnt), .mode(mode), .ext(ext),
    .slot(slot), .pix_req(pix_req), .pix_sel(pix_sel)
  );

  lf_byte_mux u_mux (
    .clk(clk), .rst(rst), .slot(slot), .pix_in(pix_in),
    .vid_out(vid_out), .hsync_n(hsync_n), .data_valid(data_valid)
  );

  // R6: a pixel on the output was requested one cycle earlier
  a_r6_req_leads: assert property (@(posedge clk) disable iff (rst)
    data_valid |-> $past(pix_req));

endmodule

// File: tb/lf_sqpix_formatter_test.sv
module lf_sqpix_formatter_test;

  localparam int CLK_PERIOD = 10;
  localparam int LN_A = 6, F2_A = 3, VB_A = 1;
  localparam int LN_B = 8, F2_B = 4, VB_B = 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mode_625 = 1'b0;
  logic       ext_sync = 1'b0;
  logic [7:0] pix_in = 8'h00;
  logic       pix_req;
  logic [1:0] pix_sel;
  logic [7:0] vid_out;
  logic       hsync_n;
  logic       data_valid;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  lf_sqpix_formatter #(
    .LINES_A(LN_A), .LINES_B(LN_B), .FLD2_A(F2_A), .FLD2_B(F2_B),
    .VBLK_A(VB_A), .VBLK_B(VB_B)
  ) uut (
    .clk(clk), .rst(rst), .mode_625(mode_625), .ext_sync(ext_sync),
    .pix_in(pix_in), .pix_req(pix_req), .pix_sel(pix_sel), .vid_out(vid_out),
    .hsync_n(hsync_n), .data_valid(data_valid)
  );

  typedef struct {
    bit valid;
    bit mode;
    bit ext;
    int v;
    int h;
  } pos_t;

  pos_t cnt_s, st1, st2;
  pos_t idle = '{valid: 0, mode: 0, ext: 0, v: 0, h: 0};
  logic [7:0] seen_pix;

  function automatic int blank_of(bit m); return m ? 344 : 272; endfunction
  function automatic int act_of(bit m);   return m ? 1536 : 1280; endfunction
  function automatic int ofs_of(bit m);   return m ? 308 : 236; endfunction
  function automatic int htot(bit m);     return 8 + blank_of(m) + act_of(m); endfunction
  function automatic int lines(bit m);    return m ? LN_B : LN_A; endfunction
  function automatic bit fflag(pos_t p);  return p.v >= (p.mode ? F2_B : F2_A); endfunction
  function automatic bit vflag(pos_t p);
    int f2 = p.mode ? F2_B : F2_A;
    int vb = p.mode ? VB_B : VB_A;
    return (p.v < vb) || (p.v >= f2 && p.v < f2 + vb);
  endfunction
  function automatic int pix_start(pos_t p);
    return p.ext ? ofs_of(p.mode) : 8 + blank_of(p.mode);
  endfunction
  function automatic bit is_pix(pos_t p);
    return p.valid && !vflag(p) && p.h >= pix_start(p)
           && p.h < pix_start(p) + act_of(p.mode);
  endfunction
  function automatic bit in_code(pos_t p);
    int s = 4 + blank_of(p.mode);
    return p.valid && !p.ext && (p.h < 4 || (p.h >= s && p.h < s + 4));
  endfunction
  function automatic logic [7:0] exp_byte(pos_t p, logic [7:0] px);
    int s = 4 + blank_of(p.mode);
    int k;
    bit f, vv, hh;
    if (!p.valid) return 8'h10;
    if (in_code(p)) begin
      hh = (p.h < 4);
      k  = hh ? p.h : p.h - s;
      f  = fflag(p);
      vv = vflag(p);
      if (k == 0) return 8'hFF;
      if (k < 3) return 8'h00;
      return {1'b1, f, vv, hh, vv ^ hh, f ^ hh, f ^ vv, f ^ vv ^ hh};
    end
    if (is_pix(p)) return px;
    return (p.h % 2 == 1) ? 8'h10 : 8'h80;
  endfunction
  function automatic string tag_of(pos_t p);
    if (!p.valid) return "R11";
    if (in_code(p)) return "R3";
    if (is_pix(p)) return p.ext ? "R8" : "R6";
    if (vflag(p) && p.h >= pix_start(p)) return "R7";
    return "R5";
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    seen_pix = pix_in;
    st2 = rst ? idle : st1;
    st1 = rst ? idle : cnt_s;
    if (rst) begin
      cnt_s = '{valid: 1, mode: mode_625, ext: ext_sync, v: 0, h: 0};
    end else if (cnt_s.h == htot(cnt_s.mode) - 1) begin
      cnt_s.h   = 0;
      cnt_s.ext = ext_sync;
      if (cnt_s.v == lines(cnt_s.mode) - 1) begin
        cnt_s.v    = 0;
        cnt_s.mode = mode_625;
      end else begin
        cnt_s.v++;
      end
    end else begin
      cnt_s.h++;
    end
    @(negedge clk);
    chk(tag_of(st2), "vid_out", int'(vid_out), int'(exp_byte(st2, seen_pix)));
    chk(st2.valid ? "R9" : "R11", "hsync_n", int'(hsync_n),
        (st2.valid && st2.h < 4) ? 0 : 1);
    chk(st2.valid ? "R9" : "R11", "data_valid", int'(data_valid), int'(is_pix(st2)));
    chk(vflag(st1) ? "R7" : "R6", "pix_req", int'(pix_req), int'(is_pix(st1)));
    if (is_pix(st1))
      chk("R6", "pix_sel", int'(pix_sel), (st1.h - pix_start(st1)) % 4);
    if (!st1.valid) chk("R11", "pix_req idle", int'(pix_req), 0);
    if (st2.valid && st2.h == 0 && !st2.ext)
      chk("R1", "end code start", int'(vid_out), 'hFF);
    if (st2.valid && st2.h == 0)
      chk("R2", "line boundary sync", int'(hsync_n), 0);
    if (st2.valid && !st2.ext && st2.h == 3)
      chk("R4", "F/V bits", int'(vid_out[6:5]), {30'd0, fflag(st2), vflag(st2)});
    if (st2.valid && !st2.ext && st2.v == 0 && st2.h == 4 + blank_of(st2.mode))
      chk("R10", "start code at frame mode", int'(vid_out), 'hFF);
    if (st2.valid && st2.ext && st2.h == 0)
      chk("R8", "no code in ext mode", int'(vid_out), 'h80);
    pix_in = 8'($urandom);
  endtask

  task automatic run(int n, int flip_rate);
    for (int i = 0; i < n; i++) begin
      tick();
      if (flip_rate > 0 && ($urandom % flip_rate) == 0) ext_sync = ~ext_sync;
    end
  endtask

  initial begin
    void'($urandom(32'd2718));
    cnt_s = idle; st1 = idle; st2 = idle;
    rst = 1'b1;
    run(3, 0);
    rst = 1'b0;
    // 525-line embedded frame, includes both fields and vertical blanking
    run(htot(0) * LN_A + 40, 0);
    // one-clock mode pulse landing exactly on the frame end
    while (!(cnt_s.h == htot(cnt_s.mode) - 1 && cnt_s.v == lines(cnt_s.mode) - 1))
      tick();
    mode_625 = 1'b1;
    tick();
    mode_625 = 1'b0;
    // 625-line frame with sync-mode changes thrown in at random
    run(htot(1) * LN_B, 1500);
    ext_sync = 1'b1;
    run(htot(0) * LN_A, 0);
    for (int s = 0; s < 5; s++) begin
      mode_625 = 1'($urandom);
      ext_sync = 1'($urandom);
      run(2000 + int'($urandom % 6000), 3000);
    end
    // reset in mid-line
    rst = 1'b1;
    run(2, 0);
    rst = 1'b0;
    mode_625 = 1'b0;
    ext_sync = 1'b0;
    run(4000, 0);
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1;
      n_chk++;
      n_err++;
      $display("FAIL R2 watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule